// File: doc/BRIEF.md
# Peripheral clock gate controller

This system-control block owns the clock enables of a group of peripheral instances, a set of GPIO ports followed by a set of UART channels. Software turns an instance's clock on or off through a gating register. A freshly enabled instance cannot be used at once, so each instance has its own wake-up counter. The counter is loaded with the latency of the instance's class when the enable bit rises from 0 to 1. A read-only ready register shows which instances have finished waking.

The block also sits on the path of every register access aimed at a peripheral, which is modelled here as an address decode. An access to an instance that is not ready ends with a bus-error response and sets an imprecise-fault flag; the faulting address is not kept. Software clears the flag by writing a 1 to it.

Requests are single-cycle. The response (valid, read data, error) is registered and appears in the cycle after the request.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset, all enable bits, ready bits, counters and the fault flag are zero. `clk_en_o` is all zero and `resp_valid_o` is low.
- R2: A write to offset 0x0 (gating register) loads one enable bit per instance. Bits 0..N_GPIO-1 are GPIO ports and the bits above them are UARTs, so bit 5 is the sixth GPIO port. `clk_en_o` follows the register, and a read of offset 0x0 returns it.
- R3: A GPIO instance becomes ready GPIO_LAT (default 2) cycles after the write that sets its enable bit. An access one cycle after that write faults, and an access two cycles after it completes.
- R4: A UART instance becomes ready UART_LAT (default 6) cycles after its enable write. Accesses 1 to 5 cycles after that write fault, and an access 6 cycles after it completes.
- R5: Peripheral instance i is reached at addresses whose top four bits equal i+1. An access to a ready instance completes with err 0 and read data 0. An access to an instance that is not ready completes with err 1.
- R6: A faulting peripheral access sets bit 10 of the fault register at offset 0x8. The bit stays set until a write to 0x8 with bit 10 set to 1, and that write clears it.
- R7: Writing 0 to an enable bit clears that instance's ready bit and its `clk_en_o` bit at the same clock edge.
- R8: Writing 1 to an enable bit that is already 1 neither restarts its counter nor clears its ready bit.
- R9: The ready register at offset 0x4 ignores writes, and every access to it completes with err 0.
- R10: Every request is answered by `resp_valid_o` exactly one cycle later. There is no response without a request.
- R11: An access to an unused control offset, or to a slot number above the last instance, returns err 1 and leaves the fault flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; top four bits select the slot |
| wdata_i | input | DATA_W | Write data |
| resp_valid_o | output | 1 | Response valid, one cycle after the request |
| rdata_o | output | DATA_W | Read data |
| err_o | output | 1 | Bus-error response |
| clk_en_o | output | N_GPIO+N_UART | Per-instance clock enable |

## Verification
A counter that is loaded with the wrong value shows up as a peripheral access that completes where it should fault, or faults where it should complete. The bench probes at each cycle offset after the enable write, so an error of a single cycle is caught at the first access that falls in the wrong window. A lost or wrongly restarted ready bit shows in the next read of offset 0x4. A fault flag that is stuck, or that never gets set, shows in the next read of offset 0x8, within one response cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned SLOT_W    = 4;
  localparam int unsigned FAULT_BIT = 10;

  typedef enum logic [1:0] {
    SEL_GATE  = 2'd0,
    SEL_READY = 2'd1,
    SEL_FAULT = 2'd2,
    SEL_NONE  = 2'd3
  } ctrl_sel_e;
endpackage

// File: rtl/pcg_wake_ctr.sv
module pcg_wake_ctr #(
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic bit_i,
  output logic en_o,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic          en_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_i) en_q <= bit_i;
      if (wr_i && bit_i && !en_q)      cnt_q <= LOAD;      // rising enable only
      else if (wr_i && !bit_i)         cnt_q <= '0;
      else if (en_q && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign en_o    = en_q;
  assign ready_o = en_q && (cnt_q == '0);

  generate
    if (LAT > 1) begin : g_wake_chk
      // R3 R4
      wake_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q && !$past(en_q)) |-> !ready_o);
    end
  endgenerate

  // R8
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ready_o) && en_q && $past(en_q)) |-> ready_o);
endmodule

// File: rtl/pcg_addr_dec.sv
module pcg_addr_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NUM    = 10
) (
  input  logic [ADDR_W-1:0]         addr_i,
  output pcg_pkg::ctrl_sel_e        sel_o,
  output logic                      periph_hit_o,
  output logic [pcg_pkg::SLOT_W-1:0] periph_idx_o,
  output logic                      unmapped_o
);
  import pcg_pkg::*;
  localparam int unsigned OFF_W = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0] slot;
  logic [OFF_W-1:0]  off;
  logic              unused_off;

  assign slot       = addr_i[ADDR_W-1:OFF_W];
  assign off        = addr_i[OFF_W-1:0];
  assign unused_off = ^off;

  always_comb begin
    sel_o        = SEL_NONE;
    periph_hit_o = 1'b0;
    periph_idx_o = slot - 1'b1;
    unmapped_o   = 1'b0;
    if (slot == '0) begin
      unique case (off)
        OFF_W'(0): sel_o = SEL_GATE;
        OFF_W'(4): sel_o = SEL_READY;
        OFF_W'(8): sel_o = SEL_FAULT;
        default:   unmapped_o = 1'b1;
      endcase
    end else if (32'(periph_idx_o) < NUM) begin
      periph_hit_o = 1'b1;
    end else begin
      unmapped_o = 1'b1;
    end
  end
endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate #(
  parameter int unsigned N_GPIO   = 6,
  parameter int unsigned N_UART   = 4,
  parameter int unsigned GPIO_LAT = 2,
  parameter int unsigned UART_LAT = 6,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic                       resp_valid_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       err_o,
  output logic [N_GPIO+N_UART-1:0]   clk_en_o
);
  import pcg_pkg::*;
  localparam int unsigned NUM    = N_GPIO + N_UART;
  localparam int unsigned SLOT_N = 2 ** SLOT_W;

  ctrl_sel_e         sel;
  logic              periph_hit, unmapped;
  logic [SLOT_W-1:0] periph_idx;

  pcg_addr_dec #(.ADDR_W(ADDR_W), .NUM(NUM)) i_dec (
    .addr_i      (addr_i),
    .sel_o       (sel),
    .periph_hit_o(periph_hit),
    .periph_idx_o(periph_idx),
    .unmapped_o  (unmapped)
  );

  logic           wr_gate;
  logic [NUM-1:0] en, ready;
  logic [SLOT_N-1:0] ready_ext;

  assign wr_gate = req_i && we_i && (sel == SEL_GATE);

  for (genvar i = 0; i < NUM; i++) begin : g_inst
    localparam int unsigned LAT = (i < N_GPIO) ? GPIO_LAT : UART_LAT;
    pcg_wake_ctr #(.LAT(LAT)) i_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_gate),
      .bit_i  (wdata_i[i]),
      .en_o   (en[i]),
      .ready_o(ready[i])
    );
  end

  assign ready_ext = SLOT_N'(ready);
  assign clk_en_o  = en;

  logic early_acc, fault_clr;
  logic fault_q, resp_q, err_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign early_acc = req_i && periph_hit && !ready_ext[periph_idx];
  assign fault_clr = req_i && we_i && (sel == SEL_FAULT) && wdata_i[FAULT_BIT];

  always_comb begin
    rd_mux = '0;
    if (!we_i && periph_hit == 1'b0) begin
      unique case (sel)
        SEL_GATE:  rd_mux = DATA_W'(en);
        SEL_READY: rd_mux = DATA_W'(ready);
        SEL_FAULT: rd_mux = DATA_W'(fault_q) << FAULT_BIT;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      resp_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q <= req_i;
      err_q  <= req_i && (early_acc || unmapped);
      rdata_q <= req_i ? rd_mux : '0;
      if (early_acc)      fault_q <= 1'b1;
      else if (fault_clr) fault_q <= 1'b0;
    end
  end

  assign resp_valid_o = resp_q;
  assign err_o        = err_q;
  assign rdata_o      = rdata_q;

  // R10
  resp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> resp_valid_o);
  // R10
  no_spurious_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !resp_valid_o);
  // R6
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !$past(fault_q)) |-> $past(req_i && periph_hit && !ready_ext[periph_idx]));
  // R9
  ready_rd_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sel == SEL_READY && !unmapped) |=> !err_o);
  // R11
  unmapped_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && unmapped && !fault_q) |=> (err_o && !fault_q));
  // R7
  clk_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gate && !wdata_i[0]) |=> (!clk_en_o[0] && !ready[0]));
endmodule

// File: tb/test_periph_clk_gate.sv
module test_periph_clk_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic        err;
    logic [31:0] rdata;
    logic [9:0]  clken;
  } vec_t;

  // one request per cycle, back to back
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 16'h0000, 32'h020, 1'b0, 32'h0,   10'h020}, // R2 enable GPIO5
    '{4'd3,  1'b1, 16'h6000, 32'h0,   1'b1, 32'h0,   10'h020}, // R3 k=1 faults
    '{4'd3,  1'b1, 16'h6000, 32'h0,   1'b0, 32'h0,   10'h020}, // R3 k=2 ok
    '{4'd3,  1'b0, 16'h0004, 32'h0,   1'b0, 32'h020, 10'h020},
    '{4'd6,  1'b0, 16'h0008, 32'h0,   1'b0, 32'h400, 10'h020}, // R6 flag set
    '{4'd6,  1'b1, 16'h0008, 32'h400, 1'b0, 32'h0,   10'h020}, // R6 clear
    '{4'd6,  1'b0, 16'h0008, 32'h0,   1'b0, 32'h0,   10'h020},
    '{4'd8,  1'b1, 16'h0000, 32'h060, 1'b0, 32'h0,   10'h060}, // R8 rewrite bit5, add UART0
    '{4'd8,  1'b0, 16'h0004, 32'h0,   1'b0, 32'h020, 10'h060},
    '{4'd4,  1'b0, 16'h7000, 32'h0,   1'b1, 32'h0,   10'h060}, // R4 k=2
    '{4'd4,  1'b0, 16'h0004, 32'h0,   1'b0, 32'h020, 10'h060}, // R4 k=3
    '{4'd4,  1'b0, 16'h7000, 32'h0,   1'b1, 32'h0,   10'h060}, // R4 k=4
    '{4'd4,  1'b0, 16'h7000, 32'h0,   1'b1, 32'h0,   10'h060}, // R4 k=5
    '{4'd5,  1'b0, 16'h7000, 32'h0,   1'b0, 32'h0,   10'h060}, // R5 R4 k=6 ok
    '{4'd4,  1'b0, 16'h0004, 32'h0,   1'b0, 32'h060, 10'h060},
    '{4'd9,  1'b1, 16'h0004, 32'h0,   1'b0, 32'h0,   10'h060}, // R9 write ignored
    '{4'd9,  1'b0, 16'h0004, 32'h0,   1'b0, 32'h060, 10'h060},
    '{4'd7,  1'b1, 16'h0000, 32'h040, 1'b0, 32'h0,   10'h040}, // R7 disable GPIO5
    '{4'd7,  1'b0, 16'h0004, 32'h0,   1'b0, 32'h040, 10'h040},
    '{4'd5,  1'b1, 16'h6000, 32'h0,   1'b1, 32'h0,   10'h040}, // R5 not ready
    '{4'd2,  1'b0, 16'h0000, 32'h0,   1'b0, 32'h040, 10'h040},
    '{4'd6,  1'b1, 16'h0008, 32'h400, 1'b0, 32'h0,   10'h040},
    '{4'd11, 1'b0, 16'hF000, 32'h0,   1'b1, 32'h0,   10'h040}, // R11 bad slot
    '{4'd11, 1'b0, 16'h0008, 32'h0,   1'b0, 32'h0,   10'h040},
    '{4'd11, 1'b0, 16'h000C, 32'h0,   1'b1, 32'h0,   10'h040}, // R11 bad offset
    '{4'd11, 1'b0, 16'h0008, 32'h0,   1'b0, 32'h0,   10'h040}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        resp_valid, err;
  logic [31:0] rdata;
  logic [9:0]  clk_en;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_clk_gate i_periph_clk_gate (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .resp_valid_o(resp_valid), .rdata_o(rdata),
    .err_o(err), .clk_en_o(clk_en)
  );

  task automatic check(input int r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [15:0] a, input logic [31:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
  endtask

  task automatic idle();
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
  endtask

  // single access, response sampled at the following negedge
  task automatic access(input logic w, input logic [15:0] a, input logic [31:0] d,
                        output logic e, output logic [31:0] q);
    @(negedge clk); drive(w, a, d);
    @(negedge clk); idle();
    e = err; q = rdata;
  endtask

  initial begin
    logic e;
    logic [31:0] q;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    check(1, "clk_en at reset", 32'(clk_en), 32'h0);
    check(1, "resp_valid at reset", 32'(resp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 16'h0004, 32'h0, e, q);
    check(1, "ready after reset", q, 32'h0);
    access(1'b0, 16'h0000, 32'h0, e, q);
    check(1, "gate after reset", q, 32'h0);

    // table walk
    @(negedge clk);
    drive(VECS[0].we, VECS[0].addr, VECS[0].wdata);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(10, $sformatf("vec %0d resp_valid", i), 32'(resp_valid), 32'h1);
      check(int'(VECS[i].req), $sformatf("vec %0d err", i), 32'(err), 32'(VECS[i].err));
      check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), rdata, VECS[i].rdata);
      check(7, $sformatf("vec %0d clk_en", i), 32'(clk_en), 32'(VECS[i].clken));
      if (i < NV - 1) drive(VECS[i+1].we, VECS[i+1].addr, VECS[i+1].wdata);
      else idle();
    end
    @(negedge clk);
    // R10 no response while idle
    check(10, "idle resp_valid", 32'(resp_valid), 32'h0);

    // R3 on GPIO0 via ready register: bit clear at k=1, set at k=2
    @(negedge clk); drive(1'b1, 16'h0000, 32'h041);
    @(negedge clk); drive(1'b0, 16'h0004, 32'h0);
    @(negedge clk); drive(1'b0, 16'h0004, 32'h0);
    check(3, "GPIO0 ready k=1", rdata & 32'h1, 32'h0);
    @(negedge clk); idle();
    check(3, "GPIO0 ready k=2", rdata & 32'h1, 32'h1);

    // R6 flag persists across unrelated accesses
    access(1'b0, 16'h8000, 32'h0, e, q); // UART1 off
    check(5, "UART1 disabled access err", 32'(e), 32'h1);
    access(1'b1, 16'h0008, 32'h0, e, q); // writing 0 keeps flag
    access(1'b0, 16'h0008, 32'h0, e, q);
    check(6, "flag kept after write 0", q, 32'h400);

    // R1 asynchronous reset mid-run
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #(CLK_PERIOD/4);
    check(1, "clk_en after async reset", 32'(clk_en), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 16'h0008, 32'h0, e, q);
    check(1, "fault flag after reset", q, 32'h0);
    access(1'b0, 16'h0004, 32'h0, e, q);
    check(1, "ready after reset", q, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule